// File: doc/BRIEF.md
# Banked Tag Word Memory Controller

This block holds 432 bits of tag storage as 27 physical words of 16 bits each. Callers see the storage as up to four logical banks and address each bank in words. For each request the controller turns a bank code and a word offset into a physical word. It then runs a read, a one-word write, a block write of up to four words, or a block erase, one word per clock. Requests that break a count rule or run past the end of the bank are refused in a single cycle and change nothing.

The bank partition is not fixed. A 5-bit length field sits in the top bits of the second word of the EPC bank, and its value selects the layout:

- **Small layout (length 9 or less):** four banks, with an 11-word EPC bank and an 8-word User bank.
- **Large layout (length above 9):** the EPC bank grows to 19 words over the space the User bank would use, the TID bank moves up behind it, and the User bank no longer exists.

The layout is taken from memory contents when a request is accepted. A change therefore takes effect from the operation that follows the write that made it.

Top module: `tagmem_ctrl`

## Requirements
- R1: Bank codes are 00 Reserved, 01 EPC, 10 TID and 11 User, placed physically in that order. When the length field is 9 or less the sizes are 4, 11, 4 and 8 words, at physical bases 0, 4, 15 and 19.
- R2: When the length field exceeds 9, the EPC bank has 19 words at base 4 and the TID bank has 4 words at base 23. Any request to bank 11 is refused.
- R3: The length field is bits [15:11] of EPC word 1. The other bits of that word do not affect the layout.
- R4: Op code 00 (read) returns `count` consecutive words, one per cycle, each with `rd_valid` high. A count of 0 is refused.
- R5: Op code 01 writes `wr_data[15:0]` to exactly one word, whatever the value of `count`.
- R6: Op code 10 (block write) writes `count` words, from 1 to 4. Word k takes `wr_data[16k+15:16k]`. A count of 0 or above 4 is refused.
- R7: Op code 11 (erase) sets `count` consecutive words to 0000h. The count may be 2 up to the whole bank. A count below 2 is refused.
- R8: A request whose offset plus word count passes the end of the selected bank, under the layout in force, is refused and modifies no word.
- R9: A refused request raises `done` and `err` together for one cycle, on the first edge after `start` is sampled, and `busy` never rises.
- R10: An accepted request of n words raises `busy` on the edge that samples `start` and handles word k on the k-th edge after it. `done` pulses and `busy` falls on the n-th edge, in the same cycle as the last read word.
- R11: `start` is ignored while `busy` is high.
- R12: Reset clears every stored word to 0000h, which gives the small layout, and drives all outputs low.
- R13: A write that changes the length field changes the layout for the next request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Request strobe, sampled when idle |
| op | input | 2 | Operation: 00 read, 01 write, 10 block write, 11 erase |
| bank | input | 2 | Logical bank code |
| addr | input | 5 | Starting word offset inside the bank |
| count | input | 5 | Number of words |
| wr_data | input | 64 | Up to four write words, word k in bits [16k+15:16k] |
| busy | output | 1 | Request in progress |
| rd_valid | output | 1 | `rd_data` holds a read word |
| rd_data | output | 16 | Read word |
| done | output | 1 | One-cycle end-of-request pulse |
| err | output | 1 | Request refused, valid with `done` |

## Verification
A refused request shows `done` and `err` one edge after `start` is sampled. An accepted n-word request shows `busy` on that same edge, delivers read word k (from 1) on the (k+1)-th edge, and ends with `done` on edge n+1.

The bench drives inputs on the falling edge. A behavioural model updates its queue of pending word actions on each rising edge, and every output is compared half a period later, so each result is checked in the cycle it is due. Directed checks then confirm read-back values, refusal flags and cycle counts, including reads issued right after a layout-changing write.

// File: rtl/tagmem_pkg.sv
package tagmem_pkg;
  typedef enum logic [1:0] {
    OP_READ  = 2'd0,
    OP_WRITE = 2'd1,
    OP_BLKWR = 2'd2,
    OP_ERASE = 2'd3
  } op_e;

  typedef enum logic [1:0] {
    BK_RSV = 2'd0,
    BK_EPC = 2'd1,
    BK_TID = 2'd2,
    BK_USR = 2'd3
  } bank_e;
endpackage

// File: rtl/tagmem_map.sv
module tagmem_map
  import tagmem_pkg::*;
#(
  parameter int DEPTH     = 27,
  parameter int RSV_W     = 4,
  parameter int EPC_S     = 11,
  parameter int EPC_L     = 19,
  parameter int TID_W     = 4,
  parameter int ADDR_W    = 5,
  parameter int CNT_W     = 5,
  parameter int PADDR_W   = 5,
  parameter int LEN_W     = 5,
  parameter int LEN_LIMIT = 9,
  parameter int BLK_MAX   = 4
) (
  input  op_e                op,
  input  bank_e              bank,
  input  logic [ADDR_W-1:0]  addr,
  input  logic [CNT_W-1:0]   count,
  input  logic [LEN_W-1:0]   len_field,
  output logic               ok,
  output logic [PADDR_W-1:0] base,
  output logic [CNT_W-1:0]   nwords
);
  localparam int SW    = ((ADDR_W > CNT_W) ? ADDR_W : CNT_W) + 1;
  localparam int USR_W = DEPTH - RSV_W - EPC_S - TID_W;

  logic               big;
  logic               cnt_ok;
  logic [SW-1:0]      size;
  logic [SW-1:0]      span;
  logic [PADDR_W-1:0] bbase;

  always_comb begin
    big    = len_field > LEN_W'(LEN_LIMIT);
    nwords = (op == OP_WRITE) ? CNT_W'(1) : count;
    case (bank)
      BK_RSV: begin
        bbase = '0;
        size  = SW'(RSV_W);
      end
      BK_EPC: begin
        bbase = PADDR_W'(RSV_W);
        size  = big ? SW'(EPC_L) : SW'(EPC_S);
      end
      BK_TID: begin
        bbase = big ? PADDR_W'(RSV_W + EPC_L) : PADDR_W'(RSV_W + EPC_S);
        size  = SW'(TID_W);
      end
      default: begin
        bbase = PADDR_W'(RSV_W + EPC_S + TID_W);
        size  = big ? '0 : SW'(USR_W);
      end
    endcase
    case (op)
      OP_READ:  cnt_ok = nwords != '0;
      OP_WRITE: cnt_ok = 1'b1;
      OP_BLKWR: cnt_ok = (nwords != '0) && (nwords <= CNT_W'(BLK_MAX));
      default:  cnt_ok = nwords >= CNT_W'(2);
    endcase
    span = SW'(addr) + SW'(nwords);
    ok   = cnt_ok && (size != '0) && (span <= size);
    base = bbase + PADDR_W'(addr);
  end
endmodule

// File: rtl/tagmem_store.sv
module tagmem_store #(
  parameter int WORD_W  = 16,
  parameter int DEPTH   = 27,
  parameter int PADDR_W = 5,
  parameter int PC_IDX  = 5,
  parameter int LEN_W   = 5
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               we,
  input  logic [PADDR_W-1:0] waddr,
  input  logic [WORD_W-1:0]  wdata,
  input  logic               re,
  input  logic [PADDR_W-1:0] raddr,
  output logic [WORD_W-1:0]  rdata,
  output logic [LEN_W-1:0]   len_field
);
  logic [WORD_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
      rdata <= '0;
    end else begin
      if (we) mem[waddr] <= wdata;
      if (re) rdata <= mem[raddr];
    end
  end

  // layout selector lives in the top bits of the protocol-control word
  assign len_field = mem[PC_IDX][WORD_W-1 -: LEN_W];
endmodule

// File: rtl/tagmem_seq.sv
module tagmem_seq
  import tagmem_pkg::*;
#(
  parameter int WORD_W  = 16,
  parameter int PADDR_W = 5,
  parameter int CNT_W   = 5,
  parameter int BLK_MAX = 4
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      start,
  input  op_e                       op,
  input  logic                      ok,
  input  logic [PADDR_W-1:0]        base,
  input  logic [CNT_W-1:0]          nwords,
  input  logic [BLK_MAX*WORD_W-1:0] wr_blk,
  output logic                      we,
  output logic [PADDR_W-1:0]        waddr,
  output logic [WORD_W-1:0]         wdata,
  output logic                      re,
  output logic [PADDR_W-1:0]        raddr,
  output logic                      busy,
  output logic                      rd_valid,
  output logic                      done,
  output logic                      err
);
  localparam int IW = (BLK_MAX > 1) ? $clog2(BLK_MAX) : 1;

  typedef enum logic {S_IDLE, S_RUN} st_e;

  st_e                st;
  op_e                op_q;
  logic [PADDR_W-1:0] ptr;
  logic [CNT_W-1:0]   left;
  logic [IW-1:0]      idx;
  logic [WORD_W-1:0]  blk_in [BLK_MAX];
  logic [WORD_W-1:0]  blk_q  [BLK_MAX];
  logic               accept;

  for (genvar g = 0; g < BLK_MAX; g++) begin : g_unpack
    assign blk_in[g] = wr_blk[g*WORD_W +: WORD_W];
  end

  assign accept = (st == S_IDLE) && start;

  always_ff @(posedge clk) begin
    if (rst) begin
      st       <= S_IDLE;
      op_q     <= OP_READ;
      ptr      <= '0;
      left     <= '0;
      idx      <= '0;
      rd_valid <= 1'b0;
      done     <= 1'b0;
      err      <= 1'b0;
      for (int i = 0; i < BLK_MAX; i++) blk_q[i] <= '0;
    end else begin
      rd_valid <= (st == S_RUN) && (op_q == OP_READ);
      done     <= ((st == S_RUN) && (left == CNT_W'(1))) || (accept && !ok);
      err      <= accept && !ok;
      if (accept && ok) begin
        st   <= S_RUN;
        op_q <= op;
        ptr  <= base;
        left <= nwords;
        idx  <= '0;
        for (int i = 0; i < BLK_MAX; i++) blk_q[i] <= blk_in[i];
      end else if (st == S_RUN) begin
        ptr  <= ptr + PADDR_W'(1);
        left <= left - CNT_W'(1);
        idx  <= idx + IW'(1);
        if (left == CNT_W'(1)) st <= S_IDLE;
      end
    end
  end

  assign busy  = (st == S_RUN);
  assign we    = busy && (op_q != OP_READ);
  assign re    = busy && (op_q == OP_READ);
  assign waddr = ptr;
  assign raddr = ptr;
  assign wdata = (op_q == OP_ERASE) ? '0 : blk_q[idx];
endmodule

// File: rtl/tagmem_ctrl.sv
module tagmem_ctrl
  import tagmem_pkg::*;
#(
  parameter int WORD_W         = 16,
  parameter int TOTAL_BITS     = 432,
  parameter int RSV_BITS       = 64,
  parameter int EPC_SMALL_BITS = 176,
  parameter int EPC_LARGE_BITS = 304,
  parameter int TID_BITS       = 64,
  parameter int ADDR_W         = 5,
  parameter int CNT_W          = 5,
  parameter int BLK_MAX        = 4,
  parameter int LEN_W          = 5,
  parameter int LEN_LIMIT      = 9,
  parameter int PC_WORD        = 1
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      start,
  input  logic [1:0]                op,
  input  logic [1:0]                bank,
  input  logic [ADDR_W-1:0]         addr,
  input  logic [CNT_W-1:0]          count,
  input  logic [BLK_MAX*WORD_W-1:0] wr_data,
  output logic                      busy,
  output logic                      rd_valid,
  output logic [WORD_W-1:0]         rd_data,
  output logic                      done,
  output logic                      err
);
  localparam int DEPTH   = TOTAL_BITS / WORD_W;
  localparam int RSV_W   = RSV_BITS / WORD_W;
  localparam int EPC_S   = EPC_SMALL_BITS / WORD_W;
  localparam int EPC_L   = EPC_LARGE_BITS / WORD_W;
  localparam int TID_W   = TID_BITS / WORD_W;
  localparam int PADDR_W = $clog2(DEPTH);
  localparam int PC_IDX  = RSV_W + PC_WORD;

  logic [LEN_W-1:0]   len_field;
  logic               map_ok;
  logic [PADDR_W-1:0] map_base;
  logic [CNT_W-1:0]   map_n;
  logic               st_we, st_re;
  logic [PADDR_W-1:0] st_waddr, st_raddr;
  logic [WORD_W-1:0]  st_wdata;

  tagmem_map #(
    .DEPTH(DEPTH), .RSV_W(RSV_W), .EPC_S(EPC_S), .EPC_L(EPC_L), .TID_W(TID_W),
    .ADDR_W(ADDR_W), .CNT_W(CNT_W), .PADDR_W(PADDR_W), .LEN_W(LEN_W),
    .LEN_LIMIT(LEN_LIMIT), .BLK_MAX(BLK_MAX)
  ) u_map (
    .op(op_e'(op)), .bank(bank_e'(bank)), .addr(addr), .count(count),
    .len_field(len_field), .ok(map_ok), .base(map_base), .nwords(map_n)
  );

  tagmem_seq #(
    .WORD_W(WORD_W), .PADDR_W(PADDR_W), .CNT_W(CNT_W), .BLK_MAX(BLK_MAX)
  ) u_seq (
    .clk(clk), .rst(rst), .start(start), .op(op_e'(op)), .ok(map_ok),
    .base(map_base), .nwords(map_n), .wr_blk(wr_data),
    .we(st_we), .waddr(st_waddr), .wdata(st_wdata), .re(st_re), .raddr(st_raddr),
    .busy(busy), .rd_valid(rd_valid), .done(done), .err(err)
  );

  tagmem_store #(
    .WORD_W(WORD_W), .DEPTH(DEPTH), .PADDR_W(PADDR_W), .PC_IDX(PC_IDX), .LEN_W(LEN_W)
  ) u_store (
    .clk(clk), .rst(rst), .we(st_we), .waddr(st_waddr), .wdata(st_wdata),
    .re(st_re), .raddr(st_raddr), .rdata(rd_data), .len_field(len_field)
  );
endmodule

// File: rtl/tagmem_ctrl_chk.sv
module tagmem_ctrl_chk (
  input logic clk,
  input logic rst,
  input logic start,
  input logic busy,
  input logic rd_valid,
  input logic done,
  input logic err
);
  a_r9_err_with_done: assert property (@(posedge clk) disable iff (rst)
    err |-> done);

  a_r9_err_no_busy: assert property (@(posedge clk) disable iff (rst)
    err |-> !busy);

  a_r10_done_ends_busy: assert property (@(posedge clk) disable iff (rst)
    (done && !err) |-> $fell(busy));

  a_r4_rdvalid_in_op: assert property (@(posedge clk) disable iff (rst)
    rd_valid |-> (busy || done));

  a_r11_busy_needs_start: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> $past(start));

  a_r12_reset_quiet: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!busy && !done && !rd_valid && !err));
endmodule

bind tagmem_ctrl tagmem_ctrl_chk u_chk (
  .clk(clk), .rst(rst), .start(start), .busy(busy),
  .rd_valid(rd_valid), .done(done), .err(err)
);

// File: tb/tb_tagmem_ctrl.sv
`timescale 1ns/1ps
module tb_tagmem_ctrl;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic [1:0]  op = '0;
  logic [1:0]  bank = '0;
  logic [4:0]  addr = '0;
  logic [4:0]  count = '0;
  logic [63:0] wr_data = '0;
  logic        busy, rd_valid, done, err;
  logic [15:0] rd_data;

  int total = 0;
  int bad = 0;

  always #2.5 clk = ~clk;

  tagmem_ctrl dut (
    .clk(clk), .rst(rst), .start(start), .op(op), .bank(bank), .addr(addr),
    .count(count), .wr_data(wr_data), .busy(busy), .rd_valid(rd_valid),
    .rd_data(rd_data), .done(done), .err(err)
  );

  // ---------------- behavioural reference model ----------------
  typedef struct { int kind; int pa; logic [15:0] d; } act_t;
  act_t        pend[$];
  logic [15:0] mdl [27];
  bit e_busy, e_rv, e_done, e_err;
  logic [15:0] e_rd;

  function automatic int bsize(int b, bit big);
    case (b)
      0: return 4;
      1: return big ? 19 : 11;
      2: return 4;
      default: return big ? 0 : 8;
    endcase
  endfunction

  function automatic int bbase(int b, bit big);
    case (b)
      0: return 0;
      1: return 4;
      2: return big ? 23 : 15;
      default: return 19;
    endcase
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      foreach (mdl[i]) mdl[i] = 16'h0;
      pend.delete();
      e_busy = 0; e_rv = 0; e_done = 0; e_err = 0; e_rd = 16'h0;
    end else begin
      e_rv = 0; e_done = 0; e_err = 0;
      if (pend.size() > 0) begin
        act_t a;
        a = pend.pop_front();
        if (a.kind == 0) begin e_rv = 1; e_rd = mdl[a.pa]; end
        else mdl[a.pa] = a.d;
        e_done = (pend.size() == 0);
        e_busy = !e_done;
      end else if (start) begin
        bit big;
        int n, sz;
        bit legal;
        big = mdl[5][15:11] > 5'd9;
        n   = (op == 2'd1) ? 1 : int'(count);
        sz  = bsize(int'(bank), big);
        case (op)
          2'd0: legal = n >= 1;
          2'd1: legal = 1;
          2'd2: legal = (n >= 1) && (n <= 4);
          default: legal = n >= 2;
        endcase
        legal = legal && (sz > 0) && (int'(addr) + n <= sz);
        if (!legal) begin
          e_done = 1; e_err = 1; e_busy = 0;
        end else begin
          for (int k = 0; k < n; k++) begin
            act_t a;
            a.kind = int'(op);
            a.pa   = bbase(int'(bank), big) + int'(addr) + k;
            a.d    = (op == 2'd3) ? 16'h0 : 16'(wr_data >> (16 * k));
            pend.push_back(a);
          end
          e_busy = 1;
        end
      end else begin
        e_busy = 0;
      end
    end
  end

  // cycle-by-cycle comparison, half a period after each rising edge (R10)
  always @(negedge clk) begin
    if (!rst) begin
      total++;
      if (busy !== e_busy || done !== e_done || err !== e_err || rd_valid !== e_rv ||
          (e_rv && rd_data !== e_rd)) begin
        bad++;
        $display("FAIL R10 cycle compare: actual busy=%0b done=%0b err=%0b rv=%0b rd=%h expected busy=%0b done=%0b err=%0b rv=%0b rd=%h",
                 busy, done, err, rd_valid, rd_data, e_busy, e_done, e_err, e_rv, e_rd);
      end
    end
  end

  // ---------------- directed stimulus ----------------
  logic [15:0] got[$];
  bit          last_err;
  int          cyc;

  task automatic chk(input bit c, input string tag, input longint act, input longint exp);
    total++;
    if (!c) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic do_op(input logic [1:0] o, input logic [1:0] b, input int a,
                       input int n, input logic [63:0] d);
    @(negedge clk);
    op = o; bank = b; addr = 5'(a); count = 5'(n); wr_data = d; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    got.delete();
    cyc = 1;
    if (rd_valid) got.push_back(rd_data);
    while (!done) begin
      @(negedge clk);
      cyc++;
      if (rd_valid) got.push_back(rd_data);
    end
    last_err = err;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    bad++;
    $display("FAIL R10 watchdog: actual=hung expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(!busy && !done && !err && !rd_valid, "R12 outputs after reset", {busy, done, err, rd_valid}, 0);

    do_op(2'd0, 2'd1, 1, 1, 0);
    chk(!last_err && got.size() == 1 && got[0] == 16'h0, "R12 cleared PC word", got[0], 0);
    chk(cyc == 2, "R10 one-word read latency", cyc, 2);

    // R5: single write, count ignored
    do_op(2'd1, 2'd0, 2, 7, 64'h0000_0000_0000_A5A5);
    chk(!last_err, "R5 write accepted", last_err, 0);
    chk(cyc == 2, "R5 one word written", cyc, 2);
    do_op(2'd0, 2'd0, 1, 3, 0);
    chk(got[0] == 16'h0 && got[1] == 16'hA5A5 && got[2] == 16'h0, "R5 neighbours intact",
        {got[0], got[1], got[2]}, 48'h0000_A5A5_0000);

    // R6: block write
    do_op(2'd2, 2'd1, 2, 4, 64'h4444_3333_2222_1111);
    chk(!last_err && cyc == 5, "R6 four-word block write", cyc, 5);
    do_op(2'd0, 2'd1, 2, 4, 0);
    chk(cyc == 5, "R4 R10 four-word read cycles", cyc, 5);
    chk(got[0] == 16'h1111 && got[3] == 16'h4444, "R6 word order", {got[0], got[3]}, 32'h1111_4444);
    do_op(2'd2, 2'd1, 0, 5, 0);
    chk(last_err, "R6 five words refused", last_err, 1);
    chk(cyc == 1, "R9 refusal after one edge", cyc, 1);
    do_op(2'd2, 2'd1, 0, 0, 0);
    chk(last_err, "R6 zero words refused", last_err, 1);

    // R4, R1: reads
    do_op(2'd0, 2'd1, 0, 0, 0);
    chk(last_err, "R4 zero-count read refused", last_err, 1);
    do_op(2'd0, 2'd1, 0, 11, 0);
    chk(!last_err && got.size() == 11, "R1 whole small EPC bank", got.size(), 11);
    do_op(2'd0, 2'd1, 10, 2, 0);
    chk(last_err, "R1 R8 small EPC overrun", last_err, 1);
    do_op(2'd1, 2'd3, 7, 1, 64'hBEEF);
    do_op(2'd0, 2'd3, 7, 1, 0);
    chk(!last_err && got[0] == 16'hBEEF, "R1 user bank word 7", got[0], 16'hBEEF);
    do_op(2'd1, 2'd2, 0, 1, 64'h7777);

    // R7: erase
    do_op(2'd3, 2'd1, 2, 1, 0);
    chk(last_err, "R7 one-word erase refused", last_err, 1);
    do_op(2'd3, 2'd1, 2, 2, 0);
    do_op(2'd0, 2'd1, 2, 3, 0);
    chk(got[0] == 0 && got[1] == 0 && got[2] == 16'h3333, "R7 erased to zero",
        {got[0], got[1], got[2]}, 48'h0000_0000_3333);

    // R8: overrun modifies nothing
    do_op(2'd2, 2'd3, 6, 4, 64'h9999_9999_9999_9999);
    chk(last_err, "R8 block write overrun", last_err, 1);
    do_op(2'd0, 2'd3, 6, 2, 0);
    chk(got[0] == 0 && got[1] == 16'hBEEF, "R8 user words intact", {got[0], got[1]}, 32'h0000_BEEF);

    // R3: only bits [15:11] count
    do_op(2'd1, 2'd1, 1, 1, 64'h4FFF);
    do_op(2'd0, 2'd3, 7, 1, 0);
    chk(!last_err && got[0] == 16'hBEEF, "R3 length 9 keeps small layout", last_err, 0);
    do_op(2'd1, 2'd1, 1, 1, 64'h07FF);
    do_op(2'd0, 2'd3, 0, 1, 0);
    chk(!last_err, "R3 low bits ignored", last_err, 0);

    // R2, R13: large layout
    do_op(2'd1, 2'd1, 1, 1, 64'h5000);
    do_op(2'd0, 2'd3, 0, 1, 0);
    chk(last_err, "R2 R13 user bank gone", last_err, 1);
    do_op(2'd0, 2'd2, 0, 1, 0);
    chk(!last_err && got[0] == 16'h0, "R2 TID relocated", got[0], 0);
    do_op(2'd0, 2'd1, 11, 1, 0);
    chk(!last_err && got[0] == 16'h7777, "R2 EPC covers old TID", got[0], 16'h7777);
    do_op(2'd0, 2'd1, 18, 1, 0);
    chk(!last_err, "R2 EPC word 18 valid", last_err, 0);
    do_op(2'd0, 2'd1, 18, 2, 0);
    chk(last_err, "R2 large EPC overrun", last_err, 1);
    do_op(2'd3, 2'd1, 0, 19, 0);
    chk(!last_err && cyc == 20, "R7 whole-bank erase", cyc, 20);
    do_op(2'd0, 2'd3, 7, 1, 0);
    chk(!last_err && got[0] == 16'hBEEF, "R13 small layout restored", got[0], 16'hBEEF);

    // R11: start while busy
    @(negedge clk);
    op = 2'd0; bank = 2'd1; addr = 5'd0; count = 5'd11; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    @(negedge clk);
    op = 2'd1; bank = 2'd0; addr = 5'd0; wr_data = 64'hDEAD; start = 1'b1;
    repeat (2) @(negedge clk);
    start = 1'b0;
    while (!done) @(negedge clk);
    do_op(2'd0, 2'd0, 0, 1, 0);
    chk(got[0] == 16'h0, "R11 start ignored while busy", got[0], 0);

    repeat (3) @(negedge clk);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule